// File: doc/BRIEF.md
# Sync-Word Gated Receive Byte Queue

This block sits behind a bit-recovery stage. It takes one demodulated bit per `rx_valid` strobe and hunts for a 16-bit synchronization word. The upper byte of that word is fixed at 0x2D and the lower byte can be reprogrammed. The hunt runs only after the fill-enable bit has gone from clear to set. When the word matches, the block packs every later bit into bytes, most significant bit first, and writes each finished byte into a 16-entry byte queue. It keeps doing this until the fill-enable bit is cleared. A match does not restart the hunt by itself. The host has to clear the fill-enable bit and set it again.

A host controls the block through 16-bit command frames on a synchronous serial port made of `sck`, `cs_n`, `mosi` and `miso`. The block oversamples this port with its system clock. One command rewrites the lower sync byte. Another command writes the fill-enable bit. A third command removes the oldest queued byte and shifts it out on `miso` during the second half of the same frame. The `fifo_en` input qualifies reads. Status outputs show whether a byte is waiting, whether the detector is locked, and whether a byte was dropped or an empty read happened.

Top module: `syncfifo_rx`

## Requirements
- R1: After reset the lower sync byte is 0xD4, fill-enable is clear, the queue is empty, `sync_locked`, `overflow`, `underflow` and `miso` are all 0.
- R2: A command is 16 bits, MSB first, sampled on rising `sck` while `cs_n` is low. It acts on its 16th bit. A frame that `cs_n` ends early has no effect.
- R3: A command whose upper byte is 0xCE loads its lower byte as the sync low byte. A match needs the last 16 received bits to equal {0x2D, low byte}, oldest bit as the MSB.
- R4: A command whose upper byte is 0xCA copies its bit 1 into fill-enable. Bytes are packed only after a match and only while fill-enable is set. They are packed MSB first and queued on their 8th bit, and the bit that completes the sync word is not data.
- R5: Clearing fill-enable stops packing at once, drops `sync_locked` and discards any partly packed byte.
- R6: Once locked, the block looks for no further sync word. Only a clear-to-set change of fill-enable restarts the hunt, and writing 1 while already set changes nothing.
- R7: Command 0xB000 removes the oldest queued byte and drives it on `miso` MSB first. The host samples it on rising edges 9 to 16, and `miso` changes after falling edges.
- R8: While `fifo_en` is low, a read command returns 0x00, removes nothing and leaves `underflow` unchanged.
- R9: A read from an empty queue returns 0x00 and sets `underflow`. The next queued byte clears it.
- R10: With 16 bytes queued, a new byte is dropped and `overflow` is set. The next successful read clears it.
- R11: `fifo_nonempty` is high exactly when at least one byte is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it also oversamples the serial port |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_bit | input | 1 | Demodulated receive bit |
| rx_valid | input | 1 | One-cycle strobe marking `rx_bit` as a new bit |
| fifo_en | input | 1 | Read qualifier for the queue |
| sck | input | 1 | Host serial clock |
| cs_n | input | 1 | Host frame select, active low |
| mosi | input | 1 | Host command data |
| miso | output | 1 | Read data to the host |
| fifo_nonempty | output | 1 | At least one byte queued |
| sync_locked | output | 1 | Sync word matched and fill-enable still set |
| overflow | output | 1 | A byte was dropped because the queue was full |
| underflow | output | 1 | An empty queue was read |

## Verification
The serial inputs pass through two synchronizer stages and an edge register. Each rising `sck` edge therefore takes effect about three system clocks later. The bench holds every `sck` phase for eight clocks and waits six clocks after `cs_n` rises before it looks at any status. The read byte is loaded about three clocks after the 8th rising edge, and each later shift follows a falling edge by the same delay. The bench samples `miso` at the end of each low phase, eight clocks after the fall. A queued byte becomes visible on the cycle after the strobe of its 8th bit, and the bench checks status only after several idle cycles.

// File: rtl/syncfifo_pkg.sv
// Shared constants and types for the sync-word gated receive queue.
// Assumes 8-bit opcodes in the upper byte of every 16-bit command.
package syncfifo_pkg;

    localparam logic [7:0] OP_SYNC_LO  = 8'hCE;  // load sync low byte
    localparam logic [7:0] OP_FILL     = 8'hCA;  // write fill-enable bit
    localparam logic [7:0] OP_READ     = 8'hB0;  // pop one byte
    localparam logic [7:0] SYNC_HI     = 8'h2D;  // fixed sync high byte
    localparam logic [7:0] SYNC_LO_RST = 8'hD4;  // sync low byte after reset
    localparam int         FILL_BIT    = 1;      // fill-enable position in the argument

    typedef enum logic [1:0] {
        DET_IDLE = 2'd0,   // fill disabled
        DET_HUNT = 2'd1,   // armed, looking for the sync word
        DET_FILL = 2'd2    // matched, packing data bytes
    } det_state_t;

endpackage

// File: rtl/syncfifo_hostif.sv
// Host command port. Oversamples sck/cs_n/mosi with clk, shifts in 16-bit
// commands MSB first on rising sck, applies sync-low and fill-enable writes
// on the last bit, and requests a pop at mid-frame for read commands.
// Assumes each sck phase lasts at least four clk periods.
module syncfifo_hostif
    import syncfifo_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              rd_req,
    output logic [BYTE_W-1:0] sync_lo,
    output logic              fill_en,
    output logic              miso
);
    localparam int CNT_W = $clog2(CMD_W + 1);
    localparam int HALF  = CMD_W / 2;

    logic [2:0]        meta_q;
    logic [2:0]        pin_q;
    logic              sck_d;
    logic              rise, fall, csel, din;
    logic [CMD_W-2:0]  cmd_sr;
    logic [CMD_W-1:0]  next_word;
    logic [CNT_W-1:0]  bit_cnt;
    logic              cmd_done;
    logic [BYTE_W-1:0] out_sr;

    // Two-stage synchronizer for the serial pins plus an sck history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 3'b010;
            pin_q  <= 3'b010;
            sck_d  <= 1'b0;
        end else begin
            meta_q <= {sck, cs_n, mosi};
            pin_q  <= meta_q;
            sck_d  <= pin_q[2];
        end
    end

    assign rise      = pin_q[2] & ~sck_d;
    assign fall      = ~pin_q[2] & sck_d;
    assign csel      = ~pin_q[1];
    assign din       = pin_q[0];
    assign next_word = {cmd_sr, din};
    assign cmd_done  = csel && rise && (bit_cnt == CNT_W'(CMD_W - 1));
    assign rd_req    = csel && rise && (bit_cnt == CNT_W'(HALF - 1))
                       && (next_word[BYTE_W-1:0] == OP_READ);
    assign miso      = out_sr[BYTE_W-1];

    // Command shift register and bit counter; a deselect restarts the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_sr  <= '0;
            bit_cnt <= '0;
        end else if (!csel) begin
            bit_cnt <= '0;
        end else if (rise) begin
            cmd_sr  <= next_word[CMD_W-2:0];
            bit_cnt <= cmd_done ? '0 : bit_cnt + 1'b1;
        end
    end

    // Configuration written by completed commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_lo <= SYNC_LO_RST;
            fill_en <= 1'b0;
        end else if (cmd_done) begin
            if (next_word[CMD_W-1 -: BYTE_W] == OP_SYNC_LO)
                sync_lo <= next_word[BYTE_W-1:0];
            if (next_word[CMD_W-1 -: BYTE_W] == OP_FILL)
                fill_en <= next_word[FILL_BIT];
        end
    end

    // Read data shifter: load at mid-frame, advance on falling edges after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sr <= '0;
        end else if (!csel || cmd_done) begin
            out_sr <= '0;
        end else if (rd_req) begin
            out_sr <= rd_byte;
        end else if (fall && (bit_cnt > CNT_W'(HALF))) begin
            out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < CNT_W'(CMD_W)); // R2

    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && next_word[CMD_W-1 -: BYTE_W] == OP_SYNC_LO)
        |=> (sync_lo == $past(next_word[BYTE_W-1:0]))); // R3

endmodule

// File: rtl/syncfifo_detect.sv
// Sync-word hunter and byte packer. Arms on a clear-to-set change of
// fill_en, compares a sliding window against sync_word, then packs later
// bits MSB first and pulses push on every complete byte.
// Assumes rx_valid is a single-cycle strobe per bit.
module syncfifo_detect
    import syncfifo_pkg::*;
#(
    parameter int SYNC_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_valid,
    input  logic              fill_en,
    input  logic [SYNC_W-1:0] sync_word,
    output logic              push,
    output logic [BYTE_W-1:0] push_data,
    output logic              locked
);
    localparam int BC_W = $clog2(BYTE_W);

    det_state_t        state;
    logic              fill_q;
    logic              arm;
    logic [SYNC_W-2:0] win_q;
    logic [SYNC_W-1:0] win_next;
    logic [BYTE_W-2:0] acc;
    logic [BC_W-1:0]   bcnt;

    assign arm       = fill_en && !fill_q;
    assign win_next  = {win_q, rx_bit};
    assign locked    = (state == DET_FILL);
    assign push      = (state == DET_FILL) && fill_en && rx_valid
                       && (bcnt == BC_W'(BYTE_W - 1));
    assign push_data = {acc, rx_bit};

    // Hunt state machine with the sliding comparison window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= DET_IDLE;
            fill_q <= 1'b0;
            win_q  <= '0;
        end else begin
            fill_q <= fill_en;
            if (!fill_en) begin
                state <= DET_IDLE;
            end else if (arm) begin
                state <= DET_HUNT;
                win_q <= '0;
            end else if (state == DET_HUNT && rx_valid) begin
                win_q <= win_next[SYNC_W-2:0];
                if (win_next == sync_word)
                    state <= DET_FILL;
            end
        end
    end

    // Byte packer, cleared whenever filling is not active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            bcnt <= '0;
        end else if (state != DET_FILL || !fill_en) begin
            acc  <= '0;
            bcnt <= '0;
        end else if (rx_valid) begin
            acc  <= push_data[BYTE_W-2:0];
            bcnt <= push ? '0 : bcnt + 1'b1;
        end
    end

    AST_NO_REHUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DET_FILL && fill_en) |=> (state != DET_HUNT)); // R6

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> !locked); // R5

endmodule

// File: rtl/syncfifo_buf.sv
// Byte queue with drop-on-full and zero-on-empty behaviour and sticky
// overflow/underflow flags. Assumes at most one push and one pop per cycle.
module syncfifo_buf #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         ovf,
    output logic         udf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = empty ? '0 : mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    // Sticky error flags, each cleared by the opposite successful operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            udf <= 1'b0;
        end else begin
            if (push && !do_push)
                ovf <= 1'b1;
            else if (do_pop)
                ovf <= 1'b0;
            if (pop && empty)
                udf <= 1'b1;
            else if (do_push)
                udf <= 1'b0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R10

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> ($stable(count) && ovf)); // R10

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (udf && empty)); // R9

endmodule

// File: rtl/syncfifo_rx.sv
// Top of the sync-word gated receive queue: host port, sync detector and
// byte queue. fifo_en qualifies host reads. Assumes a single clock domain
// apart from the oversampled serial pins.
module syncfifo_rx
    import syncfifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BYTE_W = 8,
    parameter int SYNC_W = 2 * BYTE_W,
    parameter int CMD_W  = 2 * BYTE_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic rx_valid,
    input  logic fifo_en,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    output logic fifo_nonempty,
    output logic sync_locked,
    output logic overflow,
    output logic underflow
);
    logic              rd_req, pop, fill_en, push, empty, full;
    logic [BYTE_W-1:0] sync_lo, rd_byte, head, push_data;
    logic [SYNC_W-1:0] sync_word;

    assign sync_word     = {SYNC_HI, sync_lo};
    assign pop           = rd_req && fifo_en;
    assign rd_byte       = fifo_en ? head : '0;
    assign fifo_nonempty = !empty;

    syncfifo_hostif #(.CMD_W(CMD_W), .BYTE_W(BYTE_W)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .rd_byte (rd_byte),
        .rd_req  (rd_req),
        .sync_lo (sync_lo),
        .fill_en (fill_en),
        .miso    (miso)
    );

    syncfifo_detect #(.SYNC_W(SYNC_W), .BYTE_W(BYTE_W)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .rx_valid  (rx_valid),
        .fill_en   (fill_en),
        .sync_word (sync_word),
        .push      (push),
        .push_data (push_data),
        .locked    (sync_locked)
    );

    syncfifo_buf #(.DEPTH(DEPTH), .W(BYTE_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (push_data),
        .pop   (pop),
        .head  (head),
        .empty (empty),
        .full  (full),
        .ovf   (overflow),
        .udf   (underflow)
    );

    AST_NO_PUSH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |-> !push); // R5

    AST_GATED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !fifo_en && !push) |=> ($stable(fifo_nonempty) && $stable(underflow))); // R8

endmodule

// File: tb/sim_syncfifo_rx.sv
module sim_syncfifo_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0, rx_valid = 1'b0, fifo_en = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, fifo_nonempty, sync_locked, overflow, underflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] mq[$];
    logic       m_ovf = 1'b0, m_udf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    syncfifo_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .fifo_en(fifo_en), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .fifo_nonempty(fifo_nonempty), .sync_locked(sync_locked),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void model_push(input logic [7:0] b);
        if (mq.size() < 16) begin
            mq.push_back(b);
            m_udf = 1'b0;
        end else begin
            m_ovf = 1'b1;
        end
    endfunction

    function automatic logic [7:0] model_read(input logic en);
        if (!en) return 8'h00;
        if (mq.size() == 0) begin
            m_udf = 1'b1;
            return 8'h00;
        end
        m_ovf = 1'b0;
        return mq.pop_front();
    endfunction

    // One full 16-bit command frame; collects miso over the last 8 bits.
    task automatic host_xfer(input logic [15:0] word, output logic [7:0] rdata);
        rdata = 8'h00;
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 15; i >= 0; i--) begin
            mosi = word[i];
            repeat (HP) @(negedge clk);
            if (i < 8) rdata[i] = miso;
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic host_partial(input logic [15:0] word, input int nbits);
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 15; i > 15 - nbits; i--) begin
            mosi = word[i];
            repeat (HP) @(negedge clk);
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic cmd(input logic [15:0] word);
        logic [7:0] junk;
        host_xfer(word, junk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic send_data(input logic [7:0] b);
        send_byte(b);
        model_push(b);
    endtask

    task automatic send_preamble(input int n);
        for (int i = 0; i < n; i++) send_byte(8'hAA);
    endtask

    task automatic do_read(input string req);
        logic [7:0] got, exp;
        host_xfer(16'hB000, got);
        exp = model_read(fifo_en);
        chk(req, got, exp);
    endtask

    task automatic check_flags(input string req);
        repeat (4) @(negedge clk);
        chk({req, " R11 nonempty"}, fifo_nonempty, mq.size() != 0);
        chk({req, " overflow"}, overflow, m_ovf);
        chk({req, " underflow"}, underflow, m_udf);
    endtask

    task automatic rearm();
        cmd(16'hCA00);
        cmd(16'hCA02);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] lo, b;
        int n;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 miso", miso, 0);
        chk("R1 locked", sync_locked, 0);
        check_flags("R1");

        // R9: empty read
        do_read("R9 empty read");
        check_flags("R9");

        // R1/R3/R4/R7: default sync word 0x2DD4, fill enabled
        cmd(16'hCA02);
        send_preamble(2);
        send_byte(8'h2D);
        send_byte(8'hD4);
        repeat (3) @(negedge clk);
        chk("R3 locked on default word", sync_locked, 1);
        for (int i = 0; i < 3; i++) send_data(8'($urandom));
        check_flags("R4 after fill");
        for (int i = 0; i < 3; i++) do_read("R7 read");
        check_flags("R7");

        // R6: writing 1 again while locked does not restart the hunt
        cmd(16'hCA02);
        chk("R6 still locked", sync_locked, 1);
        send_data(8'h2D);
        send_data(8'hD4);
        send_data(8'hAB);
        for (int i = 0; i < 3; i++) do_read("R6 sync bytes are data");

        // R5: clear mid-byte discards partial byte
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        cmd(16'hCA00);
        chk("R5 unlocked", sync_locked, 0);
        send_byte(8'h5C);
        check_flags("R4 disabled no fill");
        cmd(16'hCA02);
        send_preamble(1);
        send_byte(8'h2D);
        send_byte(8'hD4);
        send_data(8'h3E);
        do_read("R5 partial byte dropped");

        // R2: aborted frame leaves the sync byte unchanged
        host_partial(16'hCE77, 10);
        rearm();
        send_preamble(1);
        send_byte(8'h2D);
        send_byte(8'hD4);
        repeat (3) @(negedge clk);
        chk("R2 aborted frame ignored", sync_locked, 1);

        // R3: new low byte; old word no longer matches
        do lo = 8'($urandom); while (lo == 8'hD4);
        cmd({8'hCE, lo});
        rearm();
        send_byte(8'h2D);
        send_byte(8'hD4);
        send_byte(8'h00);
        repeat (3) @(negedge clk);
        chk("R3 old word rejected", sync_locked, 0);
        send_preamble(1);
        send_byte(8'h2D);
        send_byte(lo);
        repeat (3) @(negedge clk);
        chk("R3 new word matched", sync_locked, 1);
        send_data(8'h91);
        do_read("R3 data after new word");

        // R10: overflow on the 17th byte
        for (int i = 0; i < 17; i++) send_data(8'($urandom));
        check_flags("R10 full");
        do_read("R10 read after overflow");
        check_flags("R10 cleared");

        // R8: reads gated by fifo_en
        fifo_en = 1'b0;
        do_read("R8 gated read");
        check_flags("R8");
        fifo_en = 1'b1;
        for (int i = 0; i < 15; i++) do_read("R10 drain");
        do_read("R9 underflow after drain");
        check_flags("R9 drained");

        // Random rounds
        for (int r = 0; r < 5; r++) begin
            lo = 8'($urandom);
            cmd({8'hCE, lo});
            rearm();
            send_preamble(1 + ($urandom % 3));
            send_byte(8'h2D);
            send_byte(lo);
            n = 1 + ($urandom % 6);
            for (int i = 0; i < n; i++) begin
                b = 8'($urandom);
                send_data(b);
            end
            check_flags("R4 random");
            for (int i = 0; i <= n; i++) do_read("R7 random read");
            check_flags("R9 random");
        end

        finish_run();
    end
endmodule